// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block adds or subtracts two 64-bit operands as a row of independent lanes. A format input cuts the word into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Carries never cross from one lane into the next, so in byte format one operation performs eight separate additions, and in 16-bit format it performs four.

Each operation picks the arithmetic mode. In wraparound mode a lane keeps the low bits of its result, modulo two to the lane width. In saturating mode a lane that overflows is clamped to the nearest value it can represent. A second control bit chooses how overflow is judged: signed (two's complement) or unsigned. The single 64-bit lane always wraps, but its overflow is still reported.

The result, together with an 8-bit overflow vector that has one bit per byte position, is registered one cycle after a valid input. A single valid bit travels alongside the data.

Top module: `packedSatAdder`

## Requirements
- R1: `laneFmt` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives one 64-bit lane. Lane k occupies bits [k*w+w-1 : k*w], and no carry or borrow passes between lanes.
- R2: With `satEn`=0, each lane returns A+B when `subSel`=0 and A−B when `subSel`=1, modulo 2^w.
- R3: With `satEn`=1 and `signedSat`=0, an unsigned lane that overflows on an add returns all ones, and a lane that borrows on a subtract returns zero.
- R4: With `satEn`=1 and `signedSat`=1, a lane whose true signed result is above the maximum returns 0111…1, and one below the minimum returns 1000…0.
- R5: In 64-bit format the result always wraps, whatever the value of `satEn`.
- R6: `ovfFlags[j]` is 1 exactly when the lane containing byte j overflowed, judged signed or unsigned by `signedSat`. This holds whether the lane was clamped or wrapped, so every byte flag of an overflowing lane is set.
- R7: `outValid` equals `inValid` delayed by one clock, and the result and flags for an input appear in that same next cycle.
- R8: While `inValid` is 0, `result` and `ovfFlags` keep their previous values.
- R9: During reset, `outValid`, `result` and `ovfFlags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and controls are valid this cycle |
| laneFmt | input | 2 | Lane width select (R1 encoding) |
| subSel | input | 1 | 1 = A minus B, 0 = A plus B |
| satEn | input | 1 | 1 = saturate, 0 = wrap |
| signedSat | input | 1 | 1 = signed overflow rules, 0 = unsigned |
| opA | input | 64 | Operand A |
| opB | input | 64 | Operand B |
| outValid | output | 1 | Result valid |
| result | output | 64 | Lane-wise result |
| ovfFlags | output | 8 | Per-byte overflow flags |

## Verification
The bench drives all-ones operands with small addends in each format. A design that let carries leak across lanes would change the neighbouring lanes in those tests. Signed cases step just past 0x7F and 0x80 so that the clamp must go in the right direction. A design that clamped on the wrong sign, or that clamped the 64-bit lane, would return a boundary value where the wrapped sum is expected. Many pseudo-random vectors are compared against a per-lane model in every mode combination, which catches flags misreported for unsigned subtract borrows or flags missing from the lower bytes of a wide lane. Idle cycles confirm that the output holds.

// File: rtl/simdAddPkg.sv
package simdAddPkg;
  localparam int BYTES = 8;
  localparam int IDX_W = $clog2(BYTES);

  typedef enum logic [1:0] {
    FMT_B8  = 2'd0,
    FMT_B16 = 2'd1,
    FMT_B32 = 2'd2,
    FMT_B64 = 2'd3
  } laneFmtE;

  typedef struct packed {
    logic             load;
    logic             isSub;
    logic             clampEn;
    logic             signedMode;
    logic [BYTES-1:0] laneStart;
    logic [IDX_W-1:0] laneMask;
  } simdStrobesT;
endpackage

// File: rtl/simdAddCtrl.sv
module simdAddCtrl
  import simdAddPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  laneFmt,
  input  logic        subSel,
  input  logic        satEn,
  input  logic        signedSat,
  output simdStrobesT strobes,
  output logic        outValid
);
  logic [IDX_W-1:0] laneMask;

  // Byte index bits below the lane width are the offset within a lane.
  always_comb begin
    for (int k = 0; k < IDX_W; k++) begin
      laneMask[k] = (int'(laneFmt) > k);
    end
  end

  always_comb begin
    strobes.load       = inValid;
    strobes.isSub      = subSel;
    strobes.signedMode = signedSat;
    strobes.laneMask   = laneMask;
    // A lane spanning the whole word never clamps.
    strobes.clampEn    = satEn && !(&laneMask);
    for (int i = 0; i < BYTES; i++) begin
      strobes.laneStart[i] = ((IDX_W'(i) & laneMask) == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/simdAddPath.sv
module simdAddPath
  import simdAddPkg::*;
#(
  parameter int DATA_W = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  simdStrobesT       strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [BYTES-1:0]  ovfFlags
);
  logic [7:0]        sumB [BYTES];
  logic [BYTES-1:0]  ovfAt;
  logic [BYTES-1:0]  aSign;
  logic [DATA_W-1:0] nextRes;
  logic [BYTES-1:0]  nextFlags;

  // Byte slices; the carry is restarted at every lane start.
  always_comb begin
    logic       carry;
    logic [7:0] aB;
    logic [7:0] bB;
    logic [8:0] part;
    logic       cin;
    carry = 1'b0;
    for (int i = 0; i < BYTES; i++) begin
      aB   = opA[i*8 +: 8];
      bB   = opB[i*8 +: 8] ^ {8{strobes.isSub}};
      cin  = strobes.laneStart[i] ? strobes.isSub : carry;
      part = {1'b0, aB} + {1'b0, bB} + {8'd0, cin};
      sumB[i]  = part[7:0];
      carry    = part[8];
      aSign[i] = aB[7];
      if (strobes.signedMode)
        ovfAt[i] = (aB[7] == bB[7]) && (part[7] != aB[7]);
      else
        ovfAt[i] = part[8] ^ strobes.isSub;
    end
  end

  // Each byte takes its lane's verdict from the lane's top byte.
  always_comb begin
    logic [IDX_W-1:0] top;
    logic             isTop;
    for (int i = 0; i < BYTES; i++) begin
      top          = IDX_W'(i) | strobes.laneMask;
      isTop        = (i == int'(top));
      nextFlags[i] = ovfAt[top];
      nextRes[i*8 +: 8] = sumB[i];
      if (strobes.clampEn && ovfAt[top]) begin
        if (strobes.signedMode) begin
          if (aSign[top]) nextRes[i*8 +: 8] = isTop ? 8'h80 : 8'h00;
          else            nextRes[i*8 +: 8] = isTop ? 8'h7F : 8'hFF;
        end else begin
          nextRes[i*8 +: 8] = strobes.isSub ? 8'h00 : 8'hFF;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      ovfFlags <= '0;
    end else if (strobes.load) begin
      result   <= nextRes;
      ovfFlags <= nextFlags;
    end
  end
endmodule

// File: rtl/packedSatAdder.sv
module packedSatAdder
  import simdAddPkg::*;
#(
  parameter int DATA_W = 8 * BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        laneFmt,
  input  logic              subSel,
  input  logic              satEn,
  input  logic              signedSat,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [BYTES-1:0]  ovfFlags
);
  simdStrobesT strobes;

  simdAddCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .laneFmt(laneFmt),
    .subSel(subSel), .satEn(satEn), .signedSat(signedSat),
    .strobes(strobes), .outValid(outValid)
  );

  simdAddPath #(.DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opA(opA), .opB(opB),
    .result(result), .ovfFlags(ovfFlags)
  );
endmodule

// File: rtl/simdAddCheck.sv
module simdAddCheck (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [1:0]  laneFmt,
  input logic        subSel,
  input logic        satEn,
  input logic        signedSat,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic        outValid,
  input logic [63:0] result,
  input logic [7:0]  ovfFlags
);
  assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(ovfFlags)));

  assert_wide_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneFmt == 2'd3) |=>
      result == $past(subSel ? (opA - opB) : (opA + opB)));

  assert_flag_pairs_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneFmt == 2'd1) |=>
      (ovfFlags[1] == ovfFlags[0] && ovfFlags[3] == ovfFlags[2] &&
       ovfFlags[5] == ovfFlags[4] && ovfFlags[7] == ovfFlags[6]));

  assert_usat_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && laneFmt == 2'd0 && satEn && !signedSat && !subSel) |=>
      result[7:0] >= $past(opA[7:0]));
endmodule

bind packedSatAdder simdAddCheck u_simdAddCheck (.*);

// File: tb/test_packedSatAdder.sv
module test_packedSatAdder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  laneFmt = 2'd0;
  logic        subSel = 1'b0;
  logic        satEn = 1'b0;
  logic        signedSat = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;
  logic [7:0]  ovfFlags;

  int checks = 0;
  int errors = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;

  packedSatAdder i_packedSatAdder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .laneFmt(laneFmt),
    .subSel(subSel), .satEn(satEn), .signedSat(signedSat),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result),
    .ovfFlags(ovfFlags)
  );

  function automatic logic [63:0] nextRand(input logic [63:0] s);
    logic [63:0] x = s;
    x ^= x << 13; x ^= x >> 7; x ^= x << 17;
    return x;
  endfunction

  // Per-lane model built from R1..R6.
  function automatic void refModel(input int fmt, input bit sub, input bit sat,
      input bit sgn, input logic [63:0] a, input logic [63:0] b,
      output logic [63:0] r, output logic [7:0] f);
    int w = 8 << fmt;
    int lanes = 8 >> fmt;
    logic [65:0] m, av, bv, res, smax, smin, val;
    bit ovf;
    r = '0; f = '0;
    m = (w == 64) ? {2'b00, {64{1'b1}}} : ((66'd1 << w) - 66'd1);
    smax = m >> 1;
    smin = -(smax + 66'd1);
    for (int l = 0; l < lanes; l++) begin
      av = ({2'b00, a} >> (l * w)) & m;
      bv = ({2'b00, b} >> (l * w)) & m;
      if (sgn) begin
        if (av[w-1]) av = av | ~m;
        if (bv[w-1]) bv = bv | ~m;
      end
      res = sub ? (av - bv) : (av + bv);
      if (sgn) ovf = ($signed(res) > $signed(smax)) || ($signed(res) < $signed(smin));
      else     ovf = (res > m);
      val = res & m;
      if (ovf && sat && w < 64) begin
        if (sgn) val = $signed(res) < 0 ? (smin & m) : smax;
        else     val = sub ? 66'd0 : m;
      end
      r = r | (val[63:0] << (l * w));
      if (ovf) for (int j = 0; j < w / 8; j++) f[l * (w / 8) + j] = 1'b1;
    end
  endfunction

  task automatic checkVal(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one valid cycle, then sample the registered output at the next negedge.
  task automatic runOp(input string req, input int fmt, input bit sub, input bit sat,
      input bit sgn, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er;
    logic [7:0]  ef;
    refModel(fmt, sub, sat, sgn, a, b, er, ef);
    @(negedge clk);
    laneFmt = 2'(fmt); subSel = sub; satEn = sat; signedSat = sgn;
    opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkVal({req, " valid"}, {63'd0, outValid}, 64'd1);
    checkVal({req, " result"}, result, er);
    checkVal({req, " flags"}, {56'd0, ovfFlags}, {56'd0, ef});
  endtask

  task automatic testReset;  // R9
    @(negedge clk);
    checkVal("R9 valid", {63'd0, outValid}, 64'd0);
    checkVal("R9 result", result, 64'd0);
    checkVal("R9 flags", {56'd0, ovfFlags}, 64'd0);
  endtask

  task automatic testLaneIsolation;  // R1, R2
    runOp("R1 byte", 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    runOp("R1 half", 1, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001);
    runOp("R1 word", 2, 0, 0, 0, 64'hFFFF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001);
    runOp("R2 borrow", 0, 1, 0, 0, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101);
    runOp("R2 half sub", 1, 1, 0, 1, 64'h8000_0000_7FFF_1234, 64'h0001_0001_FFFF_0234);
  endtask

  task automatic testUnsignedSat;  // R3
    runOp("R3 add", 0, 0, 1, 0, 64'hFFF0_8000_7F01_FE10, 64'h0110_8000_8000_0101);
    runOp("R3 sub", 1, 1, 1, 0, 64'h0000_1234_8000_0005, 64'h0001_1235_7FFF_0006);
    runOp("R3 word", 2, 0, 1, 0, 64'hFFFF_FFFE_0000_0001, 64'h0000_0005_0000_0001);
  endtask

  task automatic testSignedSat;  // R4
    runOp("R4 pos", 0, 0, 1, 1, 64'h7F7F_0100_7F40_807F, 64'h0101_7F00_0140_8001);
    runOp("R4 neg", 0, 1, 1, 1, 64'h8080_7F00_80C0_0080, 64'h0101_8001_7F41_8001);
    runOp("R4 half", 1, 0, 1, 1, 64'h7FFF_8000_4000_C000, 64'h0001_FFFF_4000_BFFF);
    runOp("R4 word", 2, 1, 1, 1, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF);
  endtask

  task automatic testWideWrap;  // R5, R6
    runOp("R5 uadd", 3, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2);
    runOp("R5 sadd", 3, 0, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
    runOp("R5 ssub", 3, 1, 1, 1, 64'h8000_0000_0000_0000, 64'd1);
    runOp("R6 none", 3, 1, 0, 0, 64'd5, 64'd3);
  endtask

  task automatic testRandom;  // R1..R6 across every mode
    for (int fmt = 0; fmt < 4; fmt++)
      for (int mode = 0; mode < 8; mode++)
        for (int n = 0; n < 6; n++) begin
          logic [63:0] a, b;
          seed = nextRand(seed); a = seed;
          seed = nextRand(seed); b = seed;
          runOp("R6 random", fmt, mode[0], mode[1], mode[2], a, b);
        end
  endtask

  task automatic testHold;  // R7, R8
    logic [63:0] er;
    logic [7:0]  ef;
    runOp("R7 load", 0, 0, 1, 0, 64'hF0F0_F0F0_F0F0_F0F0, 64'h2020_2020_2020_2020);
    refModel(0, 0, 1, 0, 64'hF0F0_F0F0_F0F0_F0F0, 64'h2020_2020_2020_2020, er, ef);
    @(negedge clk);
    opA = 64'h1234_5678_9ABC_DEF0; opB = 64'hFFFF_FFFF_FFFF_FFFF; satEn = 1'b0;
    repeat (3) @(negedge clk);
    checkVal("R7 idle valid", {63'd0, outValid}, 64'd0);
    checkVal("R8 held result", result, er);
    checkVal("R8 held flags", {56'd0, ovfFlags}, {56'd0, ef});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testLaneIsolation();
    testUnsignedSat();
    testSignedSat();
    testWideWrap();
    testRandom();
    testHold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule